// File: doc/BRIEF.md
# Staged Pipeline Control Unit

This block is the control path of a five-stage in-order pipeline. In the decode stage it turns the instruction opcode into nine control bits. It splits them into three groups, one for each stage that uses them: execute, memory access and write-back. It carries the groups forward through the three inter-stage registers. A group leaves the pipeline once its stage has consumed it, so each later register is narrower than the one before it.

The surrounding datapath reads the per-stage outputs directly. It also returns the ALU zero flag that travels with the instruction now in the memory stage. The block combines that flag with the memory-stage branch bit to form the next-PC select. Every stage register loads on every clock. An all-zero control word is a bubble, and both reset and any unrecognised opcode produce one.

Top module: `pipe_ctl_top`

## Requirements
- R1: Opcode 0x00 (register-register) produces reg_dst=1, alu_op=2'b10, reg_wr=1, and all other control bits 0.
- R2: Opcode 0x23 (load) produces alu_src=1, mem_rd=1, mem_to_reg=1, reg_wr=1 and alu_op=2'b00, with reg_dst, branch and mem_wr at 0.
- R3: Opcode 0x2B (store) produces alu_src=1, mem_wr=1 and alu_op=2'b00, with every other bit (reg_wr included) at 0.
- R4: Opcode 0x04 (branch-if-equal) produces branch=1 and alu_op=2'b01, with all other bits 0.
- R5: Any other opcode produces an all-zero control word (a bubble).
- R6: The execute group (reg_dst, alu_op, alu_src) for an opcode presented before clock edge k appears on the ex_* outputs just after edge k.
- R7: The memory group (branch, mem_rd, mem_wr) of that opcode appears on the mem_* outputs just after edge k+1.
- R8: The write-back group (mem_to_reg, reg_wr) of that opcode appears on the wb_* outputs just after edge k+2.
- R9: pc_sel is 1 exactly when the memory-stage branch bit and mem_zero are both 1.
- R10: While rst_n is low, every control output, pc_sel included, is 0 after the next clock edge.
- R11: The stage registers have no enable. A new opcode on every cycle gives a new, independent result in every stage on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of all stage registers |
| id_opcode | input | OP_W | Opcode of the instruction in decode |
| mem_zero | input | 1 | ALU zero flag of the instruction in the memory stage |
| ex_reg_dst | output | 1 | Execute stage: choose the rd field as destination |
| ex_alu_op | output | 2 | Execute stage: ALU operation class |
| ex_alu_src | output | 1 | Execute stage: second operand is the immediate |
| mem_branch | output | 1 | Memory stage: instruction is a conditional branch |
| mem_rd | output | 1 | Memory stage: data memory read |
| mem_wr | output | 1 | Memory stage: data memory write |
| wb_mem_to_reg | output | 1 | Write-back stage: write loaded data, not the ALU result |
| wb_reg_wr | output | 1 | Write-back stage: register file write enable |
| pc_sel | output | 1 | Select the branch target as the next PC |

## Verification
The assertions check on every cycle that the memory group equals the one held in the decode-to-execute register a cycle earlier. They also check that the write-back group equals the one held in the execute-to-memory register a cycle earlier. The other per-cycle checks are: at most one memory-stage bit is set, a load-to-register write never appears without a register write, reg_dst only appears with the register-register ALU class, pc_sel needs both branch and zero, and reset clears everything. The exact bit pattern for each opcode, the one-, two- and three-cycle arrival of the groups, and the rule that an unknown opcode is a bubble can only be shown by the bench's scoreboard. The bench drives each opcode, unknown codes, back-to-back mixes, branches with the zero flag high and low, and a reset in mid-stream.

// File: rtl/pipe_ctl_pkg.sv
package pipe_ctl_pkg;

   localparam logic [1:0] ALU_ADDR  = 2'b00;
   localparam logic [1:0] ALU_CMP   = 2'b01;
   localparam logic [1:0] ALU_FUNCT = 2'b10;

   typedef struct packed {
      logic       reg_dst;
      logic [1:0] alu_op;
      logic       alu_src;
   } ex_grp_t;

   typedef struct packed {
      logic branch;
      logic mem_rd;
      logic mem_wr;
   } mem_grp_t;

   typedef struct packed {
      logic mem_to_reg;
      logic reg_wr;
   } wb_grp_t;

   typedef struct packed {
      wb_grp_t  wb;
      mem_grp_t mem;
      ex_grp_t  ex;
   } idex_ctl_t;

   typedef struct packed {
      wb_grp_t  wb;
      mem_grp_t mem;
   } exmem_ctl_t;

endpackage

// File: rtl/ctl_decode.sv
module ctl_decode
   import pipe_ctl_pkg::*;
#(
   parameter int              OP_W     = 6,
   parameter logic [OP_W-1:0] OP_RTYPE = 6'h00,
   parameter logic [OP_W-1:0] OP_LOAD  = 6'h23,
   parameter logic [OP_W-1:0] OP_STORE = 6'h2B,
   parameter logic [OP_W-1:0] OP_BEQ   = 6'h04
) (
   input  logic [OP_W-1:0] opcode,
   output idex_ctl_t       ctl
);

   always_comb begin
      ctl = '0;
      if (opcode == OP_RTYPE) begin
         ctl.ex.reg_dst = 1'b1;
         ctl.ex.alu_op  = ALU_FUNCT;
         ctl.wb.reg_wr  = 1'b1;
      end else if (opcode == OP_LOAD) begin
         ctl.ex.alu_src    = 1'b1;
         ctl.ex.alu_op     = ALU_ADDR;
         ctl.mem.mem_rd    = 1'b1;
         ctl.wb.mem_to_reg = 1'b1;
         ctl.wb.reg_wr     = 1'b1;
      end else if (opcode == OP_STORE) begin
         ctl.ex.alu_src = 1'b1;
         ctl.ex.alu_op  = ALU_ADDR;
         ctl.mem.mem_wr = 1'b1;
      end else if (opcode == OP_BEQ) begin
         ctl.ex.alu_op  = ALU_CMP;
         ctl.mem.branch = 1'b1;
      end
   end

endmodule

// File: rtl/ctl_stage_reg.sv
module ctl_stage_reg #(
   parameter int W         = 4,
   parameter bit ASYNC_RST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("ctl_stage_reg: W must be at least 1");
   end

   if (ASYNC_RST) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= d;
      end
   end else begin : g_sync
      always_ff @(posedge clk) begin
         if (!rst_n) q <= '0;
         else        q <= d;
      end
   end

endmodule

// File: rtl/pipe_ctl_top.sv
module pipe_ctl_top
   import pipe_ctl_pkg::*;
#(
   parameter int              OP_W      = 6,
   parameter logic [OP_W-1:0] OP_RTYPE  = 6'h00,
   parameter logic [OP_W-1:0] OP_LOAD   = 6'h23,
   parameter logic [OP_W-1:0] OP_STORE  = 6'h2B,
   parameter logic [OP_W-1:0] OP_BEQ    = 6'h04,
   parameter bit              ASYNC_RST = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [OP_W-1:0] id_opcode,
   input  logic            mem_zero,
   output logic            ex_reg_dst,
   output logic [1:0]      ex_alu_op,
   output logic            ex_alu_src,
   output logic            mem_branch,
   output logic            mem_rd,
   output logic            mem_wr,
   output logic            wb_mem_to_reg,
   output logic            wb_reg_wr,
   output logic            pc_sel
);

   localparam int IDEX_W  = $bits(idex_ctl_t);
   localparam int EXMEM_W = $bits(exmem_ctl_t);
   localparam int MEMWB_W = $bits(wb_grp_t);

   if (OP_W < 1) begin : g_bad_opw
      $error("pipe_ctl_top: OP_W must be at least 1");
   end
   if (OP_RTYPE == OP_LOAD || OP_RTYPE == OP_STORE || OP_RTYPE == OP_BEQ ||
       OP_LOAD == OP_STORE || OP_LOAD == OP_BEQ || OP_STORE == OP_BEQ) begin : g_bad_codes
      $error("pipe_ctl_top: opcode encodings must be distinct");
   end
   if (!(IDEX_W > EXMEM_W && EXMEM_W > MEMWB_W)) begin : g_bad_shrink
      $error("pipe_ctl_top: stage control words must shrink");
   end

   idex_ctl_t  id_ctl;
   idex_ctl_t  idex_q;
   exmem_ctl_t exmem_d;
   exmem_ctl_t exmem_q;
   wb_grp_t    memwb_q;

   ctl_decode #(
      .OP_W     (OP_W),
      .OP_RTYPE (OP_RTYPE),
      .OP_LOAD  (OP_LOAD),
      .OP_STORE (OP_STORE),
      .OP_BEQ   (OP_BEQ)
   ) u_decode (
      .opcode (id_opcode),
      .ctl    (id_ctl)
   );

   ctl_stage_reg #(.W(IDEX_W), .ASYNC_RST(ASYNC_RST)) u_idex (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (id_ctl),
      .q     (idex_q)
   );

   always_comb begin
      exmem_d.wb  = idex_q.wb;
      exmem_d.mem = idex_q.mem;
   end

   ctl_stage_reg #(.W(EXMEM_W), .ASYNC_RST(ASYNC_RST)) u_exmem (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (exmem_d),
      .q     (exmem_q)
   );

   ctl_stage_reg #(.W(MEMWB_W), .ASYNC_RST(ASYNC_RST)) u_memwb (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (exmem_q.wb),
      .q     (memwb_q)
   );

   assign ex_reg_dst    = idex_q.ex.reg_dst;
   assign ex_alu_op     = idex_q.ex.alu_op;
   assign ex_alu_src    = idex_q.ex.alu_src;
   assign mem_branch    = exmem_q.mem.branch;
   assign mem_rd        = exmem_q.mem.mem_rd;
   assign mem_wr        = exmem_q.mem.mem_wr;
   assign wb_mem_to_reg = memwb_q.mem_to_reg;
   assign wb_reg_wr     = memwb_q.reg_wr;
   assign pc_sel        = exmem_q.mem.branch & mem_zero;

endmodule

// File: rtl/pipe_ctl_chk.sv
module pipe_ctl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       mem_zero,
   input logic       ex_reg_dst,
   input logic [1:0] ex_alu_op,
   input logic       ex_alu_src,
   input logic       mem_branch,
   input logic       mem_rd,
   input logic       mem_wr,
   input logic       wb_mem_to_reg,
   input logic       wb_reg_wr,
   input logic       pc_sel,
   input logic [2:0] idex_mem,
   input logic [1:0] exmem_wb
);

   a_r7_mem_follows_idex: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ({mem_branch, mem_rd, mem_wr} == $past(idex_mem)));

   a_r8_wb_follows_exmem: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ({wb_mem_to_reg, wb_reg_wr} == $past(exmem_wb)));

   // R4: the memory-stage bits are mutually exclusive
   a_r4_mem_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_branch, mem_rd, mem_wr}));

   a_r2_m2r_needs_wr: assert property (@(posedge clk) disable iff (!rst_n)
      wb_mem_to_reg |-> wb_reg_wr);

   a_r1_regdst_rtype: assert property (@(posedge clk) disable iff (!rst_n)
      ex_reg_dst |-> (ex_alu_op == 2'b10 && !ex_alu_src));

   a_r9_pcsel_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
      pc_sel |-> (mem_branch && mem_zero));

   a_r10_reset_clears: assert property (@(posedge clk)
      !rst_n |=> ({ex_reg_dst, ex_alu_op, ex_alu_src, mem_branch, mem_rd, mem_wr,
                   wb_mem_to_reg, wb_reg_wr, pc_sel} == 9'b0));

endmodule

bind pipe_ctl_top pipe_ctl_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .mem_zero      (mem_zero),
   .ex_reg_dst    (ex_reg_dst),
   .ex_alu_op     (ex_alu_op),
   .ex_alu_src    (ex_alu_src),
   .mem_branch    (mem_branch),
   .mem_rd        (mem_rd),
   .mem_wr        (mem_wr),
   .wb_mem_to_reg (wb_mem_to_reg),
   .wb_reg_wr     (wb_reg_wr),
   .pc_sel        (pc_sel),
   .idex_mem      (idex_q.mem),
   .exmem_wb      (exmem_q.wb)
);

// File: tb/tb_pipe_ctl_top.sv
module tb_pipe_ctl_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] id_opcode = 6'h00;
   logic       mem_zero = 1'b0;
   logic       ex_reg_dst, ex_alu_src, mem_branch, mem_rd, mem_wr;
   logic       wb_mem_to_reg, wb_reg_wr, pc_sel;
   logic [1:0] ex_alu_op;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   pipe_ctl_top dut (
      .clk(clk), .rst_n(rst_n), .id_opcode(id_opcode), .mem_zero(mem_zero),
      .ex_reg_dst(ex_reg_dst), .ex_alu_op(ex_alu_op), .ex_alu_src(ex_alu_src),
      .mem_branch(mem_branch), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .wb_mem_to_reg(wb_mem_to_reg), .wb_reg_wr(wb_reg_wr), .pc_sel(pc_sel)
   );

   // bits: [8]reg_dst [7:6]alu_op [5]alu_src [4]branch [3]mem_rd [2]mem_wr [1]mem_to_reg [0]reg_wr
   typedef struct {
      logic [8:0] v;
      string      tag;
   } item_t;

   item_t q[$];
   item_t s_ex, s_mem, s_wb, bubble;

   function automatic item_t expect_of(input logic [5:0] op);
      item_t it;
      case (op)
         6'h00:   begin it.v = 9'b1_10_0_000_01; it.tag = "R1"; end
         6'h23:   begin it.v = 9'b0_00_1_010_11; it.tag = "R2"; end
         6'h2B:   begin it.v = 9'b0_00_1_001_00; it.tag = "R3"; end
         6'h04:   begin it.v = 9'b0_01_0_100_00; it.tag = "R4"; end
         default: begin it.v = 9'b0;             it.tag = "R5"; end
      endcase
      return it;
   endfunction

   task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic drive(input logic [5:0] op, input logic z);
      @(negedge clk);
      rst_n     = 1'b1;
      id_opcode = op;
      mem_zero  = z;
      q.push_back(expect_of(op));
   endtask

   task automatic hold_reset(input int n);
      @(negedge clk);
      rst_n     = 1'b0;
      id_opcode = 6'h23;
      repeat (n - 1) @(negedge clk);
   endtask

   // monitor: pops one expected item per edge and ages the stage model
   initial begin
      bubble.v   = 9'b0;
      bubble.tag = "R10";
      s_ex = bubble; s_mem = bubble; s_wb = bubble;
      forever begin
         @(posedge clk);
         #1;
         if (!rst_n) begin
            s_ex = bubble; s_mem = bubble; s_wb = bubble;
            chk("R10 reset outputs",
                {ex_reg_dst, ex_alu_op, ex_alu_src, mem_branch, mem_rd, mem_wr,
                 wb_mem_to_reg, wb_reg_wr, pc_sel}, 9'b0);
         end else begin
            s_wb  = s_mem;
            s_mem = s_ex;
            s_ex  = (q.size() > 0) ? q.pop_front() : bubble;
            chk({s_ex.tag, "/R6/R11 ex group"}, {5'b0, ex_reg_dst, ex_alu_op, ex_alu_src},
                {5'b0, s_ex.v[8:5]});
            chk({s_mem.tag, "/R7 mem group"}, {6'b0, mem_branch, mem_rd, mem_wr},
                {6'b0, s_mem.v[4:2]});
            chk({s_wb.tag, "/R8 wb group"}, {7'b0, wb_mem_to_reg, wb_reg_wr},
                {7'b0, s_wb.v[1:0]});
            chk("R9 pc_sel", {8'b0, pc_sel}, {8'b0, s_mem.v[4] & mem_zero});
         end
      end
   end

   initial begin
      #200000;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      hold_reset(3);
      // each kind alone, spaced by bubbles
      drive(6'h00, 1'b0); drive(6'h3F, 1'b0); drive(6'h3F, 1'b0);
      drive(6'h23, 1'b0); drive(6'h3F, 1'b0); drive(6'h3F, 1'b0);
      drive(6'h2B, 1'b0); drive(6'h3F, 1'b0); drive(6'h3F, 1'b0);
      // branch reaches memory stage with zero low, then with zero high
      drive(6'h04, 1'b0); drive(6'h3F, 1'b0); drive(6'h3F, 1'b1);
      drive(6'h04, 1'b1); drive(6'h00, 1'b1); drive(6'h3F, 1'b1);
      // zero high while a non-branch is in memory stage
      drive(6'h00, 1'b1); drive(6'h23, 1'b1); drive(6'h2B, 1'b1);
      // back-to-back mix and unknown codes
      drive(6'h23, 1'b0); drive(6'h00, 1'b0); drive(6'h2B, 1'b0);
      drive(6'h04, 1'b0); drive(6'h23, 1'b1); drive(6'h05, 1'b0);
      drive(6'h22, 1'b1); drive(6'h04, 1'b1); drive(6'h04, 1'b1);
      drive(6'h2A, 1'b1); drive(6'h00, 1'b0);
      // reset in mid-stream with a load in flight
      drive(6'h23, 1'b0); drive(6'h23, 1'b0);
      hold_reset(2);
      drive(6'h2B, 1'b0); drive(6'h00, 1'b0); drive(6'h23, 1'b0);
      drive(6'h3F, 1'b0); drive(6'h3F, 1'b0); drive(6'h3F, 1'b0);
      @(negedge clk);
      @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule